// File: doc/BRIEF.md
# JTAG Adapter Control and Status Register

This block holds the control and status word of a hardware JTAG adapter. Software never writes the word directly. It writes through two addresses. A write to the set address turns on every control bit where the data has a one. A write to the clear address turns those bits off. Bits written as zero keep their value in both cases. The control bits come out as plain level signals that drive target reset lines, target power, two indicator LEDs and the choice between the divided and the returned test clock.

The same word carries four status bits:
- a sticky flag for a target power dropout;
- a sticky flag for a reset that the target asserted by itself;
- a sticky flag for a returned-clock timeout;
- a live indication that the command FIFO is empty.

Software clears the two sense flags by writing a one to their bit through the set address, which samples and clears them together. It clears the timeout flag through the clear address. Every read returns the whole assembled word. All sense inputs arrive already synchronised to the clock.

Top module: `jcsr_top`

## Requirements
- R1: A write with `wr_clr_i`=0 (set address) makes every control bit whose data bit is 1 read back as 1 after the next clock edge. All other control bits are unchanged.
- R2: A write with `wr_clr_i`=1 (clear address) makes every control bit whose data bit is 1 read back as 0 after the next clock edge. All other control bits are unchanged.
- R3: The control bits sit at these positions, and each output equals its read-back bit:
  - bit 0 is test reset (`trst_o`);
  - bit 1 is system reset (`srst_o`);
  - bit 3 is target power (`pwr_o`);
  - bits 4 and 5 are `led_o[0]` and `led_o[1]`;
  - bit 8 selects the returned clock (`rclk_sel_o`).
- R4: After reset, power and both LEDs read 1 (word 0x38). Every other control bit and every sticky flag reads 0.
- R5: Bit 7 is the power-dropout flag. A pulse on `dropout_evt_i` sets it. A set-address write with bit 7 high clears it. Nothing else clears it; in particular a clear-address write of bit 7 has no effect.
- R6: Bit 6 is the reset-sensed flag. It is set by `srst_sense_i` and cleared by a set-address write with bit 6 high. A clear-address write of bit 6 has no effect.
- R7: Bit 10 is the returned-clock timeout flag. It is set by `rclk_timeout_i` and cleared by a clear-address write with bit 10 high. A set-address write of bit 10 has no effect.
- R8: When a sense event arrives in the same cycle as the write that clears its flag, the flag reads 1 afterwards.
- R9: Bit 9 follows `fifo_empty_i` in the same cycle and is not stored.
- R10: Bit 2 and bits 11 and up always read 0, and writes to them have no effect.
- R11: A single clear-address write of 0x401 deasserts test reset and clears the timeout flag together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_clr_i | input | 1 | Address select: 0 is the set address, 1 is the clear address |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Assembled control and status word |
| dropout_evt_i | input | 1 | Power dropout event |
| srst_sense_i | input | 1 | Target-driven reset sensed |
| rclk_timeout_i | input | 1 | Returned-clock timeout event |
| fifo_empty_i | input | 1 | Command FIFO empty, live |
| trst_o | output | 1 | Test reset assert |
| srst_o | output | 1 | System reset assert |
| pwr_o | output | 1 | Target power enable |
| led_o | output | 2 | Indicator LEDs |
| rclk_sel_o | output | 1 | Returned-clock mode select |

## Verification
The assertions check the following properties on every cycle:
- the set and clear effect on control bits;
- that control bits are stable when there is no write;
- that a flag holds until its own clearing write;
- that an event wins over a same-cycle clear;
- that unused bits stay zero and that the FIFO bit is live.

Only the bench's scenarios can show certain other behaviour. These are:
- the reset value;
- that a write to the wrong address leaves a flag alone;
- the combined 0x401 clear;
- the full agreement of the word with a reference model over long random sequences of writes and events.

// File: rtl/jcsr_pkg.sv
package jcsr_pkg;
  localparam int WORD_W = 32;

  localparam int B_TRST    = 0;
  localparam int B_SRST    = 1;
  localparam int B_PWR     = 3;
  localparam int B_LED0    = 4;
  localparam int B_LED1    = 5;
  localparam int B_SRSTSNS = 6;
  localparam int B_DROP    = 7;
  localparam int B_RCLK    = 8;
  localparam int B_FEMPTY  = 9;
  localparam int B_TMO     = 10;
  localparam int N_LED     = 2;

  localparam logic [WORD_W-1:0] CTRL_MASK =
    (WORD_W'(1) << B_TRST) | (WORD_W'(1) << B_SRST) | (WORD_W'(1) << B_PWR) |
    (WORD_W'(1) << B_LED0) | (WORD_W'(1) << B_LED1) | (WORD_W'(1) << B_RCLK);

  localparam logic [WORD_W-1:0] CTRL_RESET =
    (WORD_W'(1) << B_PWR) | (WORD_W'(1) << B_LED0) | (WORD_W'(1) << B_LED1);

  localparam logic [WORD_W-1:0] USED_MASK = CTRL_MASK |
    (WORD_W'(1) << B_SRSTSNS) | (WORD_W'(1) << B_DROP) |
    (WORD_W'(1) << B_FEMPTY) | (WORD_W'(1) << B_TMO);

  // Next value of one sticky flag: an event always wins over a clear.
  function automatic logic sticky_next(input logic cur, input logic evt,
                                       input logic clr);
    return evt | (cur & ~clr);
  endfunction

  // Next value of one control bit for a set or clear strobe.
  function automatic logic ctrl_bit_next(input logic cur, input logic set_b,
                                         input logic clr_b);
    return set_b | (cur & ~clr_b);
  endfunction
endpackage

// File: rtl/jcsr_ctrl_bits.sv
module jcsr_ctrl_bits #(
  parameter int W = 32,
  parameter logic [W-1:0] MASK = '0,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_reg
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL[i];
        else        q <= jcsr_pkg::ctrl_bit_next(q, set_i[i], clr_i[i]);
      end
      assign q_o[i] = q;
    end else begin : g_none
      logic unused_bit;
      assign unused_bit = set_i[i] ^ clr_i[i];
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/jcsr_sticky_flag.sv
module jcsr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= jcsr_pkg::sticky_next(flag_o, evt_i, clr_i);
  end
endmodule

// File: rtl/jcsr_top.sv
module jcsr_top #(
  parameter int DATA_W = jcsr_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              wr_clr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              dropout_evt_i,
  input  logic              srst_sense_i,
  input  logic              rclk_timeout_i,
  input  logic              fifo_empty_i,
  output logic              trst_o,
  output logic              srst_o,
  output logic              pwr_o,
  output logic [jcsr_pkg::N_LED-1:0] led_o,
  output logic              rclk_sel_o
);
  import jcsr_pkg::*;

  localparam logic [DATA_W-1:0] CMASK = DATA_W'(CTRL_MASK);
  localparam logic [DATA_W-1:0] CRST  = DATA_W'(CTRL_RESET);
  localparam int N_FLAG = 3;

  // Named internal events, also used by the bound checker.
  logic set_wr, clr_wr;
  logic [DATA_W-1:0] set_vec, clr_vec, ctrl_q;
  logic [N_FLAG-1:0] flag_evt, flag_clr, flag_q;
  logic [DATA_W-1:0] wr_unused;

  assign set_wr  = wr_en_i & ~wr_clr_i;
  assign clr_wr  = wr_en_i &  wr_clr_i;
  assign set_vec = set_wr ? wr_data_i : '0;
  assign clr_vec = clr_wr ? wr_data_i : '0;
  assign wr_unused = wr_data_i & ~DATA_W'(USED_MASK);

  jcsr_ctrl_bits #(.W(DATA_W), .MASK(CMASK), .RST_VAL(CRST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(ctrl_q)
  );

  // Flag 0: power dropout, flag 1: reset sensed, flag 2: clock timeout.
  assign flag_evt = {rclk_timeout_i, srst_sense_i, dropout_evt_i};
  assign flag_clr = {clr_vec[B_TMO], set_vec[B_SRSTSNS], set_vec[B_DROP]};

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
    jcsr_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .evt_i(flag_evt[f]), .clr_i(flag_clr[f]),
      .flag_o(flag_q[f])
    );
  end

  always_comb begin
    rd_data_o            = ctrl_q;
    rd_data_o[B_DROP]    = flag_q[0];
    rd_data_o[B_SRSTSNS] = flag_q[1];
    rd_data_o[B_TMO]     = flag_q[2];
    rd_data_o[B_FEMPTY]  = fifo_empty_i;
  end

  assign trst_o     = ctrl_q[B_TRST];
  assign srst_o     = ctrl_q[B_SRST];
  assign pwr_o      = ctrl_q[B_PWR];
  assign led_o      = {ctrl_q[B_LED1], ctrl_q[B_LED0]};
  assign rclk_sel_o = ctrl_q[B_RCLK];
endmodule

// File: rtl/jcsr_checker.sv
module jcsr_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              set_wr,
  input logic              clr_wr,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              dropout_evt_i,
  input logic              srst_sense_i,
  input logic              rclk_timeout_i,
  input logic              fifo_empty_i
);
  import jcsr_pkg::*;
  localparam logic [DATA_W-1:0] CM = DATA_W'(CTRL_MASK);
  localparam logic [DATA_W-1:0] UM = DATA_W'(USED_MASK);

  a_r1_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((rd_data_o & $past(wr_data_i) & CM) == ($past(wr_data_i) & CM)));

  a_r2_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((rd_data_o & $past(wr_data_i) & CM) == '0));

  a_r1_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> ((rd_data_o & CM) == ($past(rd_data_o) & CM)));

  a_r5_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[B_DROP] && !(set_wr && wr_data_i[B_DROP])) |=> rd_data_o[B_DROP]);

  a_r6_sense_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[B_SRSTSNS] && !(set_wr && wr_data_i[B_SRSTSNS])) |=> rd_data_o[B_SRSTSNS]);

  a_r7_tmo_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o[B_TMO] && !(clr_wr && wr_data_i[B_TMO])) |=> rd_data_o[B_TMO]);

  a_r8_drop_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dropout_evt_i |=> rd_data_o[B_DROP]);

  a_r8_sense_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    srst_sense_i |=> rd_data_o[B_SRSTSNS]);

  a_r8_tmo_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rclk_timeout_i |=> rd_data_o[B_TMO]);

  a_r9_fifo_live: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[B_FEMPTY] == fifo_empty_i);

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~UM) == '0);
endmodule

bind jcsr_top jcsr_checker #(.DATA_W(DATA_W)) u_jcsr_checker (
  .clk(clk), .rst_n(rst_n), .set_wr(set_wr), .clr_wr(clr_wr),
  .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
  .dropout_evt_i(dropout_evt_i), .srst_sense_i(srst_sense_i),
  .rclk_timeout_i(rclk_timeout_i), .fifo_empty_i(fifo_empty_i)
);

// File: tb/jcsr_top_bench.sv
module jcsr_top_bench;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_clr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic ev_drop = 1'b0, ev_sns = 1'b0, ev_tmo = 1'b0, fempty = 1'b0;
  logic trst, srst, pwr, rclk_sel;
  logic [1:0] led;

  int checks = 0, errors = 0;
  bit done = 0;

  // Bench reference state.
  logic [DW-1:0] m_ctrl;
  logic m_drop, m_sns, m_tmo;

  always #10 clk = ~clk;

  jcsr_top #(.DATA_W(DW)) u_jcsr_top (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_clr_i(wr_clr),
    .wr_data_i(wr_data), .rd_data_o(rd_data), .dropout_evt_i(ev_drop),
    .srst_sense_i(ev_sns), .rclk_timeout_i(ev_tmo), .fifo_empty_i(fempty),
    .trst_o(trst), .srst_o(srst), .pwr_o(pwr), .led_o(led), .rclk_sel_o(rclk_sel)
  );

  // Control bit positions listed by the bench on its own.
  function automatic bit is_ctrl(input int b);
    return b == 0 || b == 1 || b == 3 || b == 4 || b == 5 || b == 8;
  endfunction

  function automatic logic [DW-1:0] exp_word();
    logic [DW-1:0] w = '0;
    for (int b = 0; b < DW; b++) if (is_ctrl(b)) w[b] = m_ctrl[b];
    w[6] = m_sns; w[7] = m_drop; w[9] = fempty; w[10] = m_tmo;
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic [DW-1:0] e = exp_word();
    logic [DW-1:0] cm = 32'h0000_013B;
    check((rd_data & cm) == (e & cm), "R1 R2 control field", rd_data & cm, e & cm);
    check(rd_data[7] == e[7], "R5 dropout flag", DW'(rd_data[7]), DW'(e[7]));
    check(rd_data[6] == e[6], "R6 reset-sensed flag", DW'(rd_data[6]), DW'(e[6]));
    check(rd_data[10] == e[10], "R7 timeout flag", DW'(rd_data[10]), DW'(e[10]));
    check(rd_data[9] == fempty, "R9 fifo empty", DW'(rd_data[9]), DW'(fempty));
    check((rd_data & ~32'h0000_07FB) == '0, "R10 unused bits", rd_data, '0);
    check({rclk_sel, led, pwr, srst, trst} ==
          {rd_data[8], rd_data[5], rd_data[4], rd_data[3], rd_data[1], rd_data[0]},
          "R3 outputs", DW'({rclk_sel, led, pwr, srst, trst}),
          DW'({rd_data[8], rd_data[5], rd_data[4], rd_data[3], rd_data[1], rd_data[0]}));
  endtask

  // One cycle: drive at the falling edge, update the model at the rising edge,
  // compare at the next falling edge while the inputs are still applied.
  task automatic step(input bit en, input bit clr, input logic [DW-1:0] d,
                      input bit ed, input bit es, input bit et, input bit fe);
    wr_en = en; wr_clr = clr; wr_data = d;
    ev_drop = ed; ev_sns = es; ev_tmo = et; fempty = fe;
    @(posedge clk);
    for (int b = 0; b < DW; b++) begin
      if (is_ctrl(b) && en && d[b]) m_ctrl[b] = clr ? 1'b0 : 1'b1;
    end
    m_drop = ed ? 1'b1 : ((en && !clr && d[7]) ? 1'b0 : m_drop);
    m_sns  = es ? 1'b1 : ((en && !clr && d[6]) ? 1'b0 : m_sns);
    m_tmo  = et ? 1'b1 : ((en && clr && d[10]) ? 1'b0 : m_tmo);
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    step(0, 0, '0, 0, 0, 0, fempty);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    m_ctrl = 32'h38; m_drop = 0; m_sns = 0; m_tmo = 0;
    repeat (3) @(negedge clk);
    // R4: reset value.
    check(rd_data == 32'h38, "R4 reset word", rd_data, 32'h38);
    rst_n = 1'b1;
    @(negedge clk);
    check({trst, srst, pwr, led, rclk_sel} == 6'b001110, "R4 reset outputs",
          DW'({trst, srst, pwr, led, rclk_sel}), DW'(6'b001110));

    // R1 / R3: set all control bits, then R2: clear some.
    step(1, 0, 32'h0000_013B, 0, 0, 0, 0);
    step(1, 1, 32'h0000_0011, 0, 0, 0, 0);
    // R10: writes to unused bits have no effect.
    step(1, 0, 32'hFFFF_F804, 0, 0, 0, 0);
    step(1, 1, 32'hFFFF_F804, 0, 0, 0, 0);

    // R5: event sets; clear address does not clear; set address clears.
    step(0, 0, '0, 1, 0, 0, 0);
    step(1, 1, 32'h80, 0, 0, 0, 0);
    check(rd_data[7] == 1'b1, "R5 clear addr ignored", DW'(rd_data[7]), 1);
    step(1, 0, 32'h80, 0, 0, 0, 0);
    check(rd_data[7] == 1'b0, "R5 set addr clears", DW'(rd_data[7]), 0);

    // R6: same rules for the reset-sensed flag.
    step(0, 0, '0, 0, 1, 0, 0);
    step(1, 1, 32'h40, 0, 0, 0, 0);
    check(rd_data[6] == 1'b1, "R6 clear addr ignored", DW'(rd_data[6]), 1);
    step(1, 0, 32'h40, 0, 0, 0, 0);
    check(rd_data[6] == 1'b0, "R6 set addr clears", DW'(rd_data[6]), 0);

    // R7: timeout flag clears only through the clear address.
    step(0, 0, '0, 0, 0, 1, 0);
    step(1, 0, 32'h400, 0, 0, 0, 0);
    check(rd_data[10] == 1'b1, "R7 set addr ignored", DW'(rd_data[10]), 1);
    step(1, 1, 32'h400, 0, 0, 0, 0);
    check(rd_data[10] == 1'b0, "R7 clear addr clears", DW'(rd_data[10]), 0);

    // R8: event in the same cycle as its clearing write.
    step(1, 0, 32'hC0, 1, 1, 0, 0);
    check(rd_data[7:6] == 2'b11, "R8 sense flags kept", DW'(rd_data[7:6]), 3);
    step(1, 1, 32'h400, 0, 0, 1, 0);
    check(rd_data[10] == 1'b1, "R8 timeout kept", DW'(rd_data[10]), 1);

    // R11: assert test reset (timeout may fire), then one combined clear.
    step(1, 0, 32'h1, 0, 0, 1, 0);
    step(1, 1, 32'h401, 0, 0, 0, 0);
    check({trst, rd_data[10]} == 2'b00, "R11 combined clear",
          DW'({trst, rd_data[10]}), 0);

    // R9: FIFO bit follows its input with no clock edge.
    fempty = 1'b1; #1;
    check(rd_data[9] == 1'b1, "R9 live high", DW'(rd_data[9]), 1);
    fempty = 1'b0; #1;
    check(rd_data[9] == 1'b0, "R9 live low", DW'(rd_data[9]), 0);
    idle();

    // Random mix of writes and events.
    for (int n = 0; n < 3000; n++) begin
      logic [DW-1:0] d = $urandom();
      step($urandom_range(0, 2) != 0, $urandom_range(0, 1) == 1, d,
           $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 1) == 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule